// File: doc/BRIEF.md
# External Memory Bus Sequencer

The sequencer drives the multiplexed external memory bus of a small 8-bit controller. Time is counted in oscillator clocks, and six clocks form one machine cycle. An address strobe pulse (`ale`) is produced at the start of every machine cycle, whether or not any external access takes place. On that strobe, the low address byte appears on the shared address/data bus and the upper seven address bits appear on a separate high address port. A code fetch uses one machine cycle and is read with the program strobe (`psen_n`). A data read or data write uses two machine cycles and is read or written with `rd_n` or `wr_n`. The second address strobe of that pair is dropped.

The core side offers one request at a time. A request is accepted only in the last clock of the current machine cycle, or of the current long data cycle. The block then stays busy for the whole cycle that follows. It returns fetched code bytes and read data bytes together with a one-clock valid pulse.

Address decoding decides which accesses reach the pins. Code fetches at or below 3FFFh stay internal while `int_rom_en` is high. Data strobes are withheld for the top sixteen bytes of the 15-bit space. An external chip select follows the code region or the external-only setting. Two low-power modes force the pins into fixed levels.

Top module: `xbus_seq`

## Requirements
- R1: With no data move active, `ale` is high in phases 0 and 1 of every six-clock machine cycle and low in phases 2 to 5. Phase 0 is the first clock after reset release or after a cycle ends.
- R2: A data read or write cycle lasts twelve clocks. `ale` is high only in its phases 0 and 1, so the pulse that would fall in phases 6 and 7 is skipped.
- R3: During every external cycle, `ad_oe` is high and `ad_out` carries address bits 7:0 in phases 0 to 2. `hi_addr` carries address bits 14:8 for the whole cycle. Outside external cycles, `hi_addr` carries `hi_port_latch`.
- R4: A code fetch is external when `int_rom_en` is low or the address is above 3FFFh. An external fetch drives `psen_n` low in phases 3 to 5, captures `ad_in` at the end of phase 5, and pulses `rd_valid` in the next clock with that byte on `rd_data`. An internal fetch leaves `psen_n` high and the bus released, and gives no `rd_valid`.
- R5: A permitted data read or write drives `rd_n` or `wr_n` low in phases 5 to 10. A read captures `ad_in` at the end of phase 10 and pulses `rd_valid` during phase 11.
- R6: A write drives `wdata` on `ad_out` with `ad_oe` high from phase 4 through phase 11. This is one clock before the strobe falls and one clock after it rises.
- R7: For addresses 7FF0h to 7FFFh, `wr_n` and `rd_n` stay high and no `rd_valid` is given. The address and write data are still driven.
- R8: When `cfg_cs_gpio` is low and no low-power mode is active, `memcs_n` is low whenever `int_rom_en` is low. When `int_rom_en` is high, `memcs_n` is low only during fetch cycles to addresses above 3FFFh.
- R9: When `cfg_cs_gpio` is high, `memcs_n` follows `cs_gpio_val` at all times. Otherwise `memcs_n` is high in idle and power-down.
- R10: `cfg_ale_off` holds `ale` low and changes no other pin.
- R11: In idle, `ale` and `psen_n` are high, both data strobes are high and the bus is released. In power-down, `ale` and `psen_n` are low. Power-down takes precedence over idle.
- R12: `req_ready` is high only in the last clock of a cycle when no low-power mode is active. A request is taken only there. `busy` is high for exactly the following cycle of the accepted request.
- R13: While `rst_n` is low, `psen_n`, `rd_n` and `wr_n` are high, and `ad_oe`, `busy`, `req_ready` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 1 code fetch, 2 data read, 3 data write |
| req_addr | input | 15 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request taken this clock if valid |
| busy | output | 1 | An accepted cycle is in progress |
| rd_data | output | 8 | Last fetched or read byte |
| rd_valid | output | 1 | One-clock pulse for new `rd_data` |
| int_rom_en | input | 1 | High: fetches at or below 3FFFh stay internal |
| cfg_ale_off | input | 1 | Hold `ale` low |
| cfg_cs_gpio | input | 1 | `memcs_n` used as a general output |
| cs_gpio_val | input | 1 | Level for `memcs_n` in general-output use |
| mode_idle | input | 1 | Idle mode |
| mode_pdown | input | 1 | Power-down mode |
| hi_port_latch | input | 7 | High port level outside external cycles |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Multiplexed address/data out |
| ad_oe | output | 1 | Bus drive enable |
| ad_in | input | 8 | Multiplexed bus in |
| hi_addr | output | 7 | High address port |
| memcs_n | output | 1 | External memory select, active low |

## Verification
Several functions can act in the same clock. A low-power mode can become active in the very clock that would accept a request. This is provoked by holding `req_valid` high across idle and power-down entry, and it is judged by `req_ready` and `busy` staying low while the forced pin levels hold. Back-to-back requests make the end of one long data cycle coincide with the acceptance of the next. In this case the bench checks that the skipped strobe never reappears and that the new address is driven in the very next clock. A reference model in the bench runs its own phase count and memory image and compares every output on every clock.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    XOP_NONE  = 2'd0,
    XOP_FETCH = 2'd1,
    XOP_READ  = 2'd2,
    XOP_WRITE = 2'd3
  } xop_e;

  // oscillator clocks per machine cycle
  localparam int MC_CLKS    = 6;
  // phase windows (inclusive), derived from the machine cycle length
  localparam int ALE_LAST   = 1;
  localparam int ADR_LAST   = 2;
  localparam int PSEN_FIRST = 3;
  localparam int PSEN_LAST  = MC_CLKS - 1;
  localparam int WD_FIRST   = 4;
  localparam int STB_FIRST  = 5;
  localparam int STB_LAST   = 2 * MC_CLKS - 2;
  localparam int WD_LAST    = 2 * MC_CLKS - 1;

endpackage

// File: rtl/xbus_timer.sv
module xbus_timer
  import xbus_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          long_cyc,
  output logic [PW-1:0] phase,
  output logic          cyc_last
);

  localparam logic [PW-1:0] SHORT_END = PW'(MC_CLKS - 1);
  localparam logic [PW-1:0] LONG_END  = PW'(2 * MC_CLKS - 1);

  logic [PW-1:0] phase_d;

  always_comb begin
    cyc_last = (phase == (long_cyc ? LONG_END : SHORT_END));
    phase_d  = cyc_last ? '0 : phase + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_d;
  end

endmodule

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int            AW        = 15,
  parameter logic [AW-1:0] INT_TOP   = 15'h3FFF,
  parameter logic [AW-1:0] RD_WIN_LO = 15'h7FF0,
  parameter logic [AW-1:0] WR_WIN_LO = 15'h7FF0
) (
  input  xop_e          op,
  input  logic [AW-1:0] addr,
  input  logic          rom_en,
  output logic          ext,
  output logic          stb_ok
);

  always_comb begin
    ext    = 1'b0;
    stb_ok = 1'b0;
    case (op)
      XOP_FETCH: ext = !rom_en || (addr > INT_TOP);
      XOP_READ: begin
        ext    = 1'b1;
        stb_ok = (addr < RD_WIN_LO);
      end
      XOP_WRITE: begin
        ext    = 1'b1;
        stb_ok = (addr < WR_WIN_LO);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int            AW      = 15,
  parameter int            DW      = 8,
  parameter int            PW      = 4,
  parameter logic [AW-1:0] INT_TOP = 15'h3FFF,
  localparam int           HW      = AW - DW
) (
  input  logic [PW-1:0] phase,
  input  xop_e          op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          ext,
  input  logic          stb_ok,
  input  logic          rom_en,
  input  logic          ale_off,
  input  logic          cs_gpio,
  input  logic          cs_val,
  input  logic          idle,
  input  logic          pdown,
  input  logic [HW-1:0] hi_latch,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [HW-1:0] hi_addr,
  output logic          memcs_n,
  output logic          cap
);

  logic low_pwr, in_ale, in_adr, in_psen, in_stb, in_wd, in_stb_end;
  logic fetch_ext, rd_go, wr_go;

  always_comb begin
    low_pwr    = idle | pdown;
    in_ale     = (phase <= PW'(ALE_LAST));
    in_adr     = (phase <= PW'(ADR_LAST));
    in_psen    = (phase >= PW'(PSEN_FIRST)) && (phase <= PW'(PSEN_LAST));
    in_stb     = (phase >= PW'(STB_FIRST))  && (phase <= PW'(STB_LAST));
    in_wd      = (phase >= PW'(WD_FIRST))   && (phase <= PW'(WD_LAST));
    in_stb_end = (phase == PW'(STB_LAST));

    fetch_ext  = (op == XOP_FETCH) && ext;
    rd_go      = (op == XOP_READ)  && stb_ok && !low_pwr;
    wr_go      = (op == XOP_WRITE) && stb_ok && !low_pwr;

    if (pdown)        ale = 1'b0;
    else if (idle)    ale = 1'b1;
    else if (ale_off) ale = 1'b0;
    else              ale = in_ale;

    if (pdown)     psen_n = 1'b0;
    else if (idle) psen_n = 1'b1;
    else           psen_n = !(fetch_ext && in_psen);

    rd_n = !(rd_go && in_stb);
    wr_n = !(wr_go && in_stb);

    ad_oe  = !low_pwr && ((ext && in_adr) || ((op == XOP_WRITE) && in_wd));
    ad_out = in_adr ? addr[DW-1:0] : wdata;

    hi_addr = ext ? addr[AW-1:DW] : hi_latch;

    if (cs_gpio)      memcs_n = cs_val;
    else if (low_pwr) memcs_n = 1'b1;
    else if (!rom_en) memcs_n = 1'b0;
    else              memcs_n = !((op == XOP_FETCH) && (addr > INT_TOP));

    cap = !low_pwr && ((fetch_ext && (phase == PW'(PSEN_LAST))) ||
                       ((op == XOP_READ) && stb_ok && in_stb_end));
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int            AW        = 15,
  parameter int            DW        = 8,
  parameter logic [AW-1:0] INT_TOP   = 15'h3FFF,
  parameter logic [AW-1:0] RD_WIN_LO = 15'h7FF0,
  parameter logic [AW-1:0] WR_WIN_LO = 15'h7FF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             busy,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  input  logic             int_rom_en,
  input  logic             cfg_ale_off,
  input  logic             cfg_cs_gpio,
  input  logic             cs_gpio_val,
  input  logic             mode_idle,
  input  logic             mode_pdown,
  input  logic [AW-DW-1:0] hi_port_latch,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in,
  output logic [AW-DW-1:0] hi_addr,
  output logic             memcs_n
);

  localparam int PW = $clog2(2 * MC_CLKS);

  xop_e          op_q, op_d, req_kind;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wd_q, wd_d;
  logic          ext_q, ext_d, ok_q, ok_d;
  logic          dec_ext, dec_ok;
  logic [PW-1:0] phase;
  logic          cyc_last, long_cyc, low_pwr, accept, cap;
  logic [DW-1:0] rdat_q;
  logic          rv_q;

  assign req_kind = xop_e'(req_op);
  assign long_cyc = (op_q == XOP_READ) || (op_q == XOP_WRITE);
  assign low_pwr  = mode_idle | mode_pdown;

  xbus_timer #(.PW(PW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .long_cyc (long_cyc),
    .phase    (phase),
    .cyc_last (cyc_last)
  );

  xbus_decode #(
    .AW(AW), .INT_TOP(INT_TOP), .RD_WIN_LO(RD_WIN_LO), .WR_WIN_LO(WR_WIN_LO)
  ) u_decode (
    .op     (req_kind),
    .addr   (req_addr),
    .rom_en (int_rom_en),
    .ext    (dec_ext),
    .stb_ok (dec_ok)
  );

  // next cycle contents, loaded only on a cycle boundary
  always_comb begin
    accept = cyc_last && req_valid && !low_pwr;
    if (accept) begin
      op_d   = req_kind;
      addr_d = req_addr;
      wd_d   = req_wdata;
      ext_d  = dec_ext;
      ok_d   = dec_ok;
    end else begin
      op_d   = XOP_NONE;
      addr_d = addr_q;
      wd_d   = wd_q;
      ext_d  = 1'b0;
      ok_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= XOP_NONE;
      addr_q <= '0;
      wd_q   <= '0;
      ext_q  <= 1'b0;
      ok_q   <= 1'b0;
    end else if (cyc_last) begin
      op_q   <= op_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      ext_q  <= ext_d;
      ok_q   <= ok_d;
    end
  end

  xbus_pins #(.AW(AW), .DW(DW), .PW(PW), .INT_TOP(INT_TOP)) u_pins (
    .phase    (phase),
    .op       (op_q),
    .addr     (addr_q),
    .wdata    (wd_q),
    .ext      (ext_q),
    .stb_ok   (ok_q),
    .rom_en   (int_rom_en),
    .ale_off  (cfg_ale_off),
    .cs_gpio  (cfg_cs_gpio),
    .cs_val   (cs_gpio_val),
    .idle     (mode_idle),
    .pdown    (mode_pdown),
    .hi_latch (hi_port_latch),
    .ale      (ale),
    .psen_n   (psen_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .hi_addr  (hi_addr),
    .memcs_n  (memcs_n),
    .cap      (cap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      rdat_q <= '0;
    end else begin
      rv_q <= cap;
      if (cap) rdat_q <= ad_in;
    end
  end

  assign rd_valid  = rv_q;
  assign rd_data   = rdat_q;
  assign req_ready = cyc_last && !low_pwr;
  assign busy      = (op_q != XOP_NONE);

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic req_ready,
  input logic busy,
  input logic rd_valid,
  input logic mode_idle,
  input logic mode_pdown
);

  assert_ale_psen_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && !psen_n));

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_rv_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_wr_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  assert_wr_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(ad_oe));

  assert_pdown_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_pdown |-> (!ale && !psen_n));

  assert_lowpwr_refuse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_idle || mode_pdown) |-> !req_ready);

  assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(busy));

endmodule

bind xbus_seq xbus_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ale        (ale),
  .psen_n     (psen_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .ad_oe      (ad_oe),
  .req_ready  (req_ready),
  .busy       (busy),
  .rd_valid   (rd_valid),
  .mode_idle  (mode_idle),
  .mode_pdown (mode_pdown)
);

// File: tb/xbus_seq_bench.sv
`timescale 1ns/1ps
module xbus_seq_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 0;
  logic [1:0]  req_op = 0;
  logic [14:0] req_addr = 0;
  logic [7:0]  req_wdata = 0;
  logic        int_rom_en = 1, cfg_ale_off = 0, cfg_cs_gpio = 0, cs_gpio_val = 1;
  logic        mode_idle = 0, mode_pdown = 0;
  logic [6:0]  hi_port_latch = 7'h55;
  logic        req_ready, busy, rd_valid, ale, psen_n, rd_n, wr_n, ad_oe, memcs_n;
  logic [7:0]  rd_data, ad_out, ad_in;
  logic [6:0]  hi_addr;

  xbus_seq u_xbus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid),
    .int_rom_en(int_rom_en), .cfg_ale_off(cfg_ale_off),
    .cfg_cs_gpio(cfg_cs_gpio), .cs_gpio_val(cs_gpio_val),
    .mode_idle(mode_idle), .mode_pdown(mode_pdown),
    .hi_port_latch(hi_port_latch), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .hi_addr(hi_addr), .memcs_n(memcs_n)
  );

  int total = 0, bad = 0;
  bit run = 0;

  function automatic logic [7:0] code_byte(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  // external memories, addressed through the pins only
  logic [7:0] dmem [0:255];
  logic [7:0] ref_mem [0:255];
  logic [7:0] lat_lo = 0;
  initial for (int i = 0; i < 256; i++) begin
    dmem[i] = 8'(i) ^ 8'hC3;
    ref_mem[i] = 8'(i) ^ 8'hC3;
  end
  always @(negedge ale) lat_lo = ad_out;
  always @(posedge wr_n) if (run) dmem[lat_lo] = ad_out;
  assign ad_in = !psen_n ? code_byte({hi_addr, lat_lo}) :
                 !rd_n   ? dmem[lat_lo] : 8'hFF;

  // reference model state
  int         m_pos = 0, m_len = 6;
  logic [1:0] m_op = 0;
  logic [14:0] m_addr = 0;
  logic [7:0] m_wd = 0, e_rd = 0;
  bit         m_ext = 0, m_ok = 0, e_rv = 0;

  always @(posedge clk) if (run) begin
    bit lp, rv;
    lp = mode_idle || mode_pdown;
    rv = 0;
    if (!lp && m_op == 1 && m_ext && m_pos == 5) begin rv = 1; e_rd = code_byte(m_addr); end
    if (!lp && m_op == 2 && m_ok && m_pos == 10) begin rv = 1; e_rd = ref_mem[m_addr[7:0]]; end
    if (!lp && m_op == 3 && m_ok && m_pos == 10) ref_mem[m_addr[7:0]] = m_wd;
    e_rv = rv;
    if (m_pos == m_len - 1) begin
      if (req_valid && !lp && req_op != 0) begin
        m_op = req_op; m_addr = req_addr; m_wd = req_wdata;
        m_ext = (req_op == 1) ? (!int_rom_en || req_addr > 15'h3FFF) : 1'b1;
        m_ok  = (req_addr < 15'h7FF0);
      end else begin
        m_op = 0; m_ext = 0; m_ok = 0;
      end
      m_len = (m_op >= 2) ? 12 : 6;
      m_pos = 0;
    end else m_pos++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every output on every clock, away from the edges
  always @(negedge clk) begin
    #2;
    if (run) begin
      bit lp, e_ale, e_psen, e_rdn, e_wrn, e_oe, e_cs;
      lp = mode_idle || mode_pdown;
      e_ale  = mode_pdown ? 0 : mode_idle ? 1 : cfg_ale_off ? 0 : (m_pos < 2);
      e_psen = mode_pdown ? 0 : mode_idle ? 1 :
               !(m_op == 1 && m_ext && m_pos >= 3 && m_pos <= 5);
      e_rdn  = lp ? 1 : !(m_op == 2 && m_ok && m_pos >= 5 && m_pos <= 10);
      e_wrn  = lp ? 1 : !(m_op == 3 && m_ok && m_pos >= 5 && m_pos <= 10);
      e_oe   = lp ? 0 : ((m_ext && m_pos <= 2) || (m_op == 3 && m_pos >= 4 && m_pos <= 11));
      e_cs   = cfg_cs_gpio ? cs_gpio_val : lp ? 1 : !int_rom_en ? 0 :
               !(m_op == 1 && m_addr > 15'h3FFF);
      chk("R1/R2/R10/R11 ale", ale, e_ale);
      chk("R4/R11 psen_n", psen_n, e_psen);
      chk("R5/R7 rd_n", rd_n, e_rdn);
      chk("R5/R7 wr_n", wr_n, e_wrn);
      chk("R3/R6 ad_oe", ad_oe, e_oe);
      if (e_oe) chk("R3/R6 ad_out", ad_out, (m_pos <= 2) ? m_addr[7:0] : m_wd);
      chk("R3 hi_addr", hi_addr, m_ext ? m_addr[14:8] : hi_port_latch);
      chk("R8/R9 memcs_n", memcs_n, e_cs);
      chk("R12 req_ready", req_ready, (m_pos == m_len - 1) && !lp);
      chk("R12 busy", busy, m_op != 0);
      chk("R4/R5/R7 rd_valid", rd_valid, e_rv);
      if (e_rv) chk("R4/R5 rd_data", rd_data, e_rd);
    end
  end

  task automatic send(input logic [1:0] op, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_op = 0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitc(3);
    // R13 reset state
    chk("R13 psen_n", psen_n, 1); chk("R13 rd_n", rd_n, 1); chk("R13 wr_n", wr_n, 1);
    chk("R13 ad_oe", ad_oe, 0); chk("R13 busy", busy, 0);
    chk("R13 req_ready", req_ready, 0); chk("R13 rd_valid", rd_valid, 0);
    rst_n = 1; run = 1;
    waitc(14);                                  // R1 free-running pulses
    send(1, 15'h0100, 0);                       // R4 internal fetch
    send(1, 15'h4123, 0);                       // R4 external fetch, R8 select
    waitc(8);
    int_rom_en = 0;                             // R8 external-only
    send(1, 15'h0077, 0);
    waitc(8);
    int_rom_en = 1;
    send(3, 15'h0042, 8'hA5);                   // R2 R5 R6 write
    send(2, 15'h0042, 0);                       // R5 read back
    send(3, 15'h7FF5, 8'h3C);                   // R7 suppressed write
    send(2, 15'h00F5, 0);                       // R7 memory untouched
    send(2, 15'h7FF8, 0);                       // R7 suppressed read
    send(2, 15'h1042, 0);
    send(3, 15'h0010, 8'h11);                   // back to back
    send(3, 15'h0011, 8'h22);
    send(2, 15'h0010, 0);
    send(1, 15'h5000, 0);
    waitc(14);
    hi_port_latch = 7'h2A;
    cfg_ale_off = 1; waitc(14);                 // R10
    send(1, 15'h0200, 0); waitc(8);
    cfg_ale_off = 0;
    cfg_cs_gpio = 1; cs_gpio_val = 0; waitc(8); // R9
    cs_gpio_val = 1; waitc(8);
    cfg_cs_gpio = 0;
    // R11 R12 idle with a pending request
    @(negedge clk); req_valid = 1; req_op = 2; req_addr = 15'h0042; mode_idle = 1;
    waitc(20);
    req_valid = 0; req_op = 0; waitc(1);
    mode_idle = 0; waitc(8);
    @(negedge clk); req_valid = 1; req_op = 1; req_addr = 15'h4000; mode_pdown = 1;
    waitc(4); mode_idle = 1; waitc(10);         // R11 power-down wins
    req_valid = 0; req_op = 0; waitc(1);
    mode_idle = 0; mode_pdown = 0; waitc(8);
    send(2, 15'h0011, 0);
    waitc(20);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule